// File: doc/BRIEF.md
# Cache Maintenance Command Queue

This block is the register front-end of an outer-cache controller's maintenance engine. Several CPU ports reach one shared set of command registers (operation word, start address, length). Each port also has its own registration-status and queue-status registers. A CPU claims the shared registers by writing the operation word. It fills in the address and length when the operation covers a range. It then commits by reading its registration-status register. That read either pushes the command into a shared FIFO or reports why the attempt was refused, and in both cases it gives up the claim.

A single executor stub takes commands from the FIFO in arrival order and holds each one for a fixed number of cycles. At the end it raises the end flag of the CPU that submitted the command, if that command asked for notification. A primitive register provides a drain barrier: a read of it is held off until the queue is empty and the executor is idle. A write of the prefetch-flush code emits a one-cycle pulse.

Top module: `cmq_top`

## Requirements
- R1: Register word offsets are 0 operation word, 1 start address, 2 length, 3 registration status, 4 queue status, 5 primitive. Operation-word fields are: bits 18:17 scope (0 = address range, 1 = whole cache), bit 15 completion notify, bits 3:0 command (0 invalidate, 1 clean, 2 flush). Offsets 0 to 2 read back the last accepted write, and a queued command appears on the exec_* outputs with these fields.
- R2: A write of the operation word while the shared registers are unclaimed makes the writer the owner. When several ports do this in the same cycle, the lowest port index wins. Ownership ends only when the owner reads its registration-status register.
- R3: A write to offsets 0, 1 or 2 from a port that is not the owner is ignored and sets that port's failure flag. That port's next registration-status read returns bit 0 = 1 and clears the flag.
- R4: An owner's registration-status read returns bit 1 = 1 if the FIFO is full. It returns bit 0 = 1 if a range-scope command has length 0 (or the owner's failure flag is set). If neither bit is set it returns 0 and pushes the command.
- R5: Commands run one at a time in FIFO order. Each occupies the executor for LAT cycles, and the next one starts straight after. exec_start pulses for one cycle at the start of each command.
- R6: Queue status for each port: bit 0 = that port has a command queued or running, bit 1 = the executor is running that port's command, bit 2 = end flag. The end flag is set when a notify command of that port completes, and it is cleared by writing the queue-status register with bit 2 = 1. Writing 0 there has no effect.
- R7: A read of the primitive register is held (bus_ready low) until the FIFO is empty and the executor idle. A write with low nibble 9 gives a one-cycle pf_flush pulse in the next cycle. A write with code 8 has no visible effect.
- R8: After reset the executor is idle, every port is ready, pf_flush is low, and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | NCPU | Per-port access request |
| bus_we | input | NCPU | Per-port write (1) / read (0) |
| bus_addr | input | NCPU*3 | Per-port register word offset |
| bus_wdata | input | NCPU*32 | Per-port write data |
| bus_rdata | output | NCPU*32 | Per-port read data, valid while request and ready are high |
| bus_ready | output | NCPU | Per-port access completes this cycle |
| exec_start | output | 1 | One-cycle pulse when a command starts |
| exec_busy | output | 1 | Executor holds a command |
| exec_cpu | output | 4 | Submitting port of the running command |
| exec_cmd | output | 4 | Command code of the running command |
| exec_scope | output | 2 | Scope of the running command |
| exec_notify | output | 1 | Notify request of the running command |
| exec_addr | output | 32 | Start address of the running command |
| exec_size | output | 32 | Length of the running command |
| pf_flush | output | 1 | Prefetch-buffer flush pulse |

## Verification
The bench builds the block with three ports, a FIFO depth of two and an executor latency of 20 cycles. With a depth of two, the queue-full refusal is reached after three quick registrations. The long latency keeps the first command running while later registrations and status reads happen, so the running and queued status bits can be seen at the ports. Three ports make it possible to test same-cycle claims where a port other than port 0 wins, and to test refusals seen by a port that never held the claim.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned RAW  = 3;
  localparam int unsigned CIDW = 4;

  localparam logic [RAW-1:0] OFS_MODE  = 3'd0;
  localparam logic [RAW-1:0] OFS_ADDR  = 3'd1;
  localparam logic [RAW-1:0] OFS_SIZE  = 3'd2;
  localparam logic [RAW-1:0] OFS_SETC  = 3'd3;
  localparam logic [RAW-1:0] OFS_QSTAT = 3'd4;
  localparam logic [RAW-1:0] OFS_PRIM  = 3'd5;

  localparam logic [1:0] SCOPE_RANGE   = 2'd0;
  localparam logic [3:0] PRIM_PF_FLUSH = 4'd9;

  typedef struct packed {
    logic [CIDW-1:0] cpu;
    logic            notify;
    logic [1:0]      scope;
    logic [3:0]      cmd;
    logic [DW-1:0]   addr;
    logic [DW-1:0]   size;
  } cmd_entry_t;
endpackage

// File: rtl/cmq_rst_sync.sv
module cmq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cmq_fifo.sv
module cmq_fifo
  import cmq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  cmd_entry_t din,
  input  logic       pop,
  output cmd_entry_t head,
  output logic       full,
  output logic       empty
);
  localparam int unsigned PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNW = $clog2(DEPTH + 1);

  cmd_entry_t     mem_q [DEPTH];
  logic [PW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CNW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    if (push && !pop)      cnt_d = cnt_q + CNW'(1);
    else if (pop && !push) cnt_d = cnt_q - CNW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  // R4: a refused registration must never reach a full queue
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: the executor only takes from a non-empty queue
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
  import cmq_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_empty,
  input  cmd_entry_t head,
  output logic       pop,
  output logic       start,
  output logic       busy,
  output logic       done,
  output cmd_entry_t cur
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q, busy_d, start_q;
  logic [CW-1:0] cnt_q, cnt_d;
  cmd_entry_t    cur_q, cur_d;

  assign done  = busy_q && (cnt_q == '0);
  assign pop   = !fifo_empty && (!busy_q || done);
  assign start = start_q;
  assign busy  = busy_q;
  assign cur   = cur_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    if (pop) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
      cur_d  = head;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= pop;
      cnt_q   <= cnt_d;
      cur_q   <= cur_d;
    end
  end

  // R5: a running command keeps the executor and its identity until it ends
  assert_exec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> (busy_q && $stable(cur_q)));
endmodule

// File: rtl/cmq_regs.sv
module cmq_regs
  import cmq_pkg::*;
#(
  parameter int unsigned NCPU  = 2,
  parameter int unsigned DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCPU-1:0]     bus_req,
  input  logic [NCPU-1:0]     bus_we,
  input  logic [NCPU*RAW-1:0] bus_addr,
  input  logic [NCPU*DW-1:0]  bus_wdata,
  output logic [NCPU*DW-1:0]  bus_rdata,
  output logic [NCPU-1:0]     bus_ready,
  input  logic                fifo_full,
  input  logic                drained,
  input  logic                exec_busy,
  input  logic                exec_done,
  input  cmd_entry_t          exec_cur,
  output logic                push,
  output cmd_entry_t          push_entry,
  output logic                pf_flush
);
  localparam int unsigned PCW = $clog2(DEPTH + 2);

  logic                lock_q, lock_d;
  logic [CIDW-1:0]     owner_q, owner_d;
  logic [DW-1:0]       mode_q, mode_d, addr_q, addr_d, size_q, size_d;
  logic [NCPU-1:0]     fail_q, fail_d, ef_q, ef_d, ef_set, ef_clr;
  logic [PCW-1:0]      pend_q [NCPU];
  logic [PCW-1:0]      pend_d [NCPU];
  logic                pf_q, pf_d;
  logic                grant_vld, own_rd, zero_fail;
  logic [CIDW-1:0]     grant_id;

  assign pf_flush   = pf_q;
  assign zero_fail  = (mode_q[18:17] == SCOPE_RANGE) && (size_q == '0);
  assign push_entry = '{cpu: owner_q, notify: mode_q[15], scope: mode_q[18:17],
                        cmd: mode_q[3:0], addr: addr_q, size: size_q};

  always_comb begin
    lock_d    = lock_q;
    owner_d   = owner_q;
    mode_d    = mode_q;
    addr_d    = addr_q;
    size_d    = size_q;
    fail_d    = fail_q;
    pf_d      = 1'b0;
    push      = 1'b0;
    own_rd    = 1'b0;
    grant_vld = 1'b0;
    grant_id  = '0;
    bus_rdata = '0;
    bus_ready = '1;
    ef_set    = '0;
    ef_clr    = '0;

    // claim arbitration: lowest port index wins while unclaimed
    for (int c = 0; c < NCPU; c++) begin
      if (!lock_q && !grant_vld && bus_req[c] && bus_we[c] &&
          bus_addr[c*RAW +: RAW] == OFS_MODE) begin
        grant_vld = 1'b1;
        grant_id  = CIDW'(c);
      end
    end

    for (int c = 0; c < NCPU; c++) begin
      logic [RAW-1:0] a;
      logic           is_own, acc, shared_wr, wr, rd;
      a         = bus_addr[c*RAW +: RAW];
      wr        = bus_req[c] && bus_we[c];
      rd        = bus_req[c] && !bus_we[c];
      is_own    = lock_q && (owner_q == CIDW'(c));
      acc       = is_own || (grant_vld && grant_id == CIDW'(c));
      shared_wr = wr && (a == OFS_MODE || a == OFS_ADDR || a == OFS_SIZE);

      if (shared_wr && acc) begin
        unique case (a)
          OFS_MODE: mode_d = bus_wdata[c*DW +: DW];
          OFS_ADDR: addr_d = bus_wdata[c*DW +: DW];
          default:  size_d = bus_wdata[c*DW +: DW];
        endcase
      end
      if (shared_wr && !acc) fail_d[c] = 1'b1;

      if (wr && a == OFS_QSTAT && bus_wdata[c*DW + 2]) ef_clr[c] = 1'b1;
      if (wr && a == OFS_PRIM && bus_wdata[c*DW +: 4] == PRIM_PF_FLUSH) pf_d = 1'b1;
      if (exec_done && exec_cur.notify && exec_cur.cpu == CIDW'(c)) ef_set[c] = 1'b1;

      if (rd) begin
        case (a)
          OFS_MODE: bus_rdata[c*DW +: DW] = mode_q;
          OFS_ADDR: bus_rdata[c*DW +: DW] = addr_q;
          OFS_SIZE: bus_rdata[c*DW +: DW] = size_q;
          OFS_SETC: begin
            fail_d[c] = 1'b0;
            if (is_own) begin
              own_rd = 1'b1;
              lock_d = 1'b0;
              bus_rdata[c*DW +: DW] = {30'd0, fifo_full, zero_fail | fail_q[c]};
              push = !fifo_full && !zero_fail && !fail_q[c];
            end else begin
              bus_rdata[c*DW +: DW] = {31'd0, fail_q[c]};
            end
          end
          OFS_QSTAT: bus_rdata[c*DW +: DW] =
            {29'd0, ef_q[c], exec_busy && (exec_cur.cpu == CIDW'(c)), pend_q[c] != '0};
          OFS_PRIM: bus_ready[c] = drained;
          default: bus_rdata[c*DW +: DW] = '0;
        endcase
      end
    end

    if (grant_vld) begin
      lock_d  = 1'b1;
      owner_d = grant_id;
    end

    for (int c = 0; c < NCPU; c++) begin
      logic inc, dec;
      inc       = push && (owner_q == CIDW'(c));
      dec       = exec_done && (exec_cur.cpu == CIDW'(c));
      pend_d[c] = pend_q[c] + PCW'(inc) - PCW'(dec);
    end
    ef_d = (ef_q & ~ef_clr) | ef_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      mode_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      fail_q  <= '0;
      ef_q    <= '0;
      pf_q    <= 1'b0;
      for (int c = 0; c < NCPU; c++) pend_q[c] <= '0;
    end else begin
      lock_q  <= lock_d;
      owner_q <= owner_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      size_q  <= size_d;
      fail_q  <= fail_d;
      ef_q    <= ef_d;
      pf_q    <= pf_d;
      for (int c = 0; c < NCPU; c++) pend_q[c] <= pend_d[c];
    end
  end

  // R2: the claim survives every cycle without the owner's status read
  assert_owner_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !own_rd) |=> (lock_q && $stable(owner_q)));

  generate
    for (genvar g = 0; g < NCPU; g++) begin : g_ef_chk
      // R6: a clear without a simultaneous completion empties the end flag
      assert_ef_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ef_clr[g] && !ef_set[g]) |=> !ef_q[g]);
      // R6: a notified completion always leaves the end flag set
      assert_ef_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ef_set[g] |=> ef_q[g]);
    end
  endgenerate
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int unsigned NCPU  = 2,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LAT   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCPU-1:0]     bus_req,
  input  logic [NCPU-1:0]     bus_we,
  input  logic [NCPU*RAW-1:0] bus_addr,
  input  logic [NCPU*DW-1:0]  bus_wdata,
  output logic [NCPU*DW-1:0]  bus_rdata,
  output logic [NCPU-1:0]     bus_ready,
  output logic                exec_start,
  output logic                exec_busy,
  output logic [CIDW-1:0]     exec_cpu,
  output logic [3:0]          exec_cmd,
  output logic [1:0]          exec_scope,
  output logic                exec_notify,
  output logic [DW-1:0]       exec_addr,
  output logic [DW-1:0]       exec_size,
  output logic                pf_flush
);
  logic       rst_sn, push, pop, full, empty, done, busy;
  cmd_entry_t push_entry, head, cur;

  cmq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  cmq_regs #(.NCPU(NCPU), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .fifo_full(full), .drained(empty && !busy), .exec_busy(busy),
    .exec_done(done), .exec_cur(cur),
    .push(push), .push_entry(push_entry), .pf_flush(pf_flush)
  );

  cmq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sn), .push(push), .din(push_entry), .pop(pop),
    .head(head), .full(full), .empty(empty)
  );

  cmq_exec #(.LAT(LAT)) u_exec (
    .clk(clk), .rst_n(rst_sn), .fifo_empty(empty), .head(head),
    .pop(pop), .start(exec_start), .busy(busy), .done(done), .cur(cur)
  );

  assign exec_busy   = busy;
  assign exec_cpu    = cur.cpu;
  assign exec_cmd    = cur.cmd;
  assign exec_scope  = cur.scope;
  assign exec_notify = cur.notify;
  assign exec_addr   = cur.addr;
  assign exec_size   = cur.size;
endmodule

// File: tb/sim_cmq_top.sv
`timescale 1ns/1ps
module sim_cmq_top;
  localparam int NC = 3;
  localparam int DEP = 2;
  localparam int LT = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    req, we;
  logic [NC*3-1:0]  addr;
  logic [NC*32-1:0] wdata;
  logic [NC*32-1:0] bus_rdata;
  logic [NC-1:0]    bus_ready;
  logic exec_start, exec_busy, exec_notify, pf_flush;
  logic [3:0] exec_cpu, exec_cmd;
  logic [1:0] exec_scope;
  logic [31:0] exec_addr, exec_size;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nrec = 0;
  logic [3:0]  r_cpu [8];
  logic [3:0]  r_cmd [8];
  logic [1:0]  r_scope [8];
  logic [31:0] r_addr [8];
  logic [31:0] r_size [8];
  int          r_cyc [8];

  always #5 clk = ~clk;

  cmq_top #(.NCPU(NC), .DEPTH(DEP), .LAT(LT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .exec_start(exec_start), .exec_busy(exec_busy), .exec_cpu(exec_cpu),
    .exec_cmd(exec_cmd), .exec_scope(exec_scope), .exec_notify(exec_notify),
    .exec_addr(exec_addr), .exec_size(exec_size), .pf_flush(pf_flush)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (exec_start && nrec < 8) begin
      r_cpu[nrec]   = exec_cpu;
      r_cmd[nrec]   = exec_cmd;
      r_scope[nrec] = exec_scope;
      r_addr[nrec]  = exec_addr;
      r_size[nrec]  = exec_size;
      r_cyc[nrec]   = cyc;
      nrec = nrec + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  cpu;
    logic        w;
    logic [2:0]  ofs;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        chk;
    logic [3:0]  rq;
  } vec_t;

  // offsets: 0 op word, 1 addr, 2 len, 3 reg status, 4 queue status, 5 primitive
  localparam vec_t TBL [18] = '{
    '{2'd0, 1'b1, 3'd0, 32'h0002_8002, 32'h0, 1'b0, 4'd2}, // claim: all, notify, flush
    '{2'd1, 1'b1, 3'd0, 32'h0000_8001, 32'h0, 1'b0, 4'd3}, // refused
    '{2'd1, 1'b0, 3'd3, 32'h0, 32'h1, 1'b1, 4'd3},
    '{2'd0, 1'b0, 3'd0, 32'h0, 32'h0002_8002, 1'b1, 4'd1},
    '{2'd0, 1'b0, 3'd3, 32'h0, 32'h0, 1'b1, 4'd2},         // commit A
    '{2'd1, 1'b1, 3'd0, 32'h0000_8001, 32'h0, 1'b0, 4'd2}, // range clean
    '{2'd1, 1'b1, 3'd1, 32'h0000_1000, 32'h0, 1'b0, 4'd1},
    '{2'd1, 1'b1, 3'd2, 32'h0000_0040, 32'h0, 1'b0, 4'd1},
    '{2'd1, 1'b0, 3'd3, 32'h0, 32'h0, 1'b1, 4'd4},         // commit B
    '{2'd2, 1'b1, 3'd0, 32'h0000_8000, 32'h0, 1'b0, 4'd4},
    '{2'd2, 1'b1, 3'd2, 32'h0, 32'h0, 1'b0, 4'd4},
    '{2'd2, 1'b0, 3'd3, 32'h0, 32'h1, 1'b1, 4'd4},         // zero length
    '{2'd2, 1'b1, 3'd0, 32'h0002_8000, 32'h0, 1'b0, 4'd4},
    '{2'd2, 1'b0, 3'd3, 32'h0, 32'h0, 1'b1, 4'd4},         // commit C
    '{2'd0, 1'b1, 3'd0, 32'h0002_8001, 32'h0, 1'b0, 4'd4},
    '{2'd0, 1'b0, 3'd3, 32'h0, 32'h2, 1'b1, 4'd4},         // queue full
    '{2'd0, 1'b0, 3'd4, 32'h0, 32'h3, 1'b1, 4'd6},         // queued + running
    '{2'd1, 1'b0, 3'd4, 32'h0, 32'h1, 1'b1, 4'd6}          // queued only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input int c, input logic w, input logic [2:0] a, input logic [31:0] d,
                     output logic [31:0] rv, output int waits);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c*3 +: 3] = a; wdata[c*32 +: 32] = d;
    waits = 0;
    #1;
    while (!bus_ready[c]) begin
      waits++;
      @(negedge clk); #1;
    end
    rv = bus_rdata[c*32 +: 32];
    @(posedge clk); #1;
    req[c] = 1'b0; we[c] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int wt;
    req = '0; we = '0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    check("R8 busy", {31'd0, exec_busy}, 32'h0);
    check("R8 ready", {29'd0, bus_ready}, 32'h7);
    check("R8 pf_flush", {31'd0, pf_flush}, 32'h0);
    txn(0, 1'b0, 3'd4, 32'h0, rv, wt); check("R8 qstat", rv, 32'h0);
    txn(2, 1'b0, 3'd3, 32'h0, rv, wt); check("R8 regstat", rv, 32'h0);

    for (int i = 0; i < 18; i++) begin
      txn(int'(TBL[i].cpu), TBL[i].w, TBL[i].ofs, TBL[i].wd, rv, wt);
      if (TBL[i].chk) check($sformatf("R%0d vec%0d", TBL[i].rq, i), rv, TBL[i].ex);
    end

    // R7 drain barrier
    txn(0, 1'b0, 3'd5, 32'h0, rv, wt);
    check("R7 read was held", {31'd0, wt > 0}, 32'h1);
    check("R7 idle after drain", {31'd0, exec_busy}, 32'h0);
    // R6 end flags after notify commands
    txn(0, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 cpu0 end", rv, 32'h4);
    txn(1, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 cpu1 end", rv, 32'h4);
    txn(2, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 cpu2 end", rv, 32'h4);
    // R5 order and spacing, R1 fields
    check("R5 rec count", nrec, 32'd3);
    check("R5 first cpu", {28'd0, r_cpu[0]}, 32'd0);
    check("R5 second cpu", {28'd0, r_cpu[1]}, 32'd1);
    check("R5 third cpu", {28'd0, r_cpu[2]}, 32'd2);
    check("R5 spacing", r_cyc[1] - r_cyc[0], LT);
    check("R1 flush all", {26'd0, r_scope[0], r_cmd[0]}, {26'd0, 2'd1, 4'd2});
    check("R1 range clean", {26'd0, r_scope[1], r_cmd[1]}, {26'd0, 2'd0, 4'd1});
    check("R1 range addr", r_addr[1], 32'h1000);
    check("R1 range len", r_size[1], 32'h40);
    check("R1 inv all", {26'd0, r_scope[2], r_cmd[2]}, {26'd0, 2'd1, 4'd0});

    // R6 clear semantics
    txn(0, 1'b1, 3'd4, 32'h4, rv, wt);
    txn(0, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 clear", rv, 32'h0);
    txn(1, 1'b1, 3'd4, 32'h0, rv, wt);
    txn(1, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 write 0 keeps", rv, 32'h4);

    // R6 command without notify leaves end flag low
    txn(1, 1'b1, 3'd4, 32'h4, rv, wt);
    txn(1, 1'b1, 3'd0, 32'h0002_0000, rv, wt);
    txn(1, 1'b0, 3'd3, 32'h0, rv, wt); check("R4 commit no-notify", rv, 32'h0);
    txn(0, 1'b0, 3'd5, 32'h0, rv, wt);
    txn(1, 1'b0, 3'd4, 32'h0, rv, wt); check("R6 no notify", rv, 32'h0);

    // R7 prefetch flush pulse and sync code
    txn(2, 1'b1, 3'd5, 32'h9, rv, wt);
    @(negedge clk);
    check("R7 pf pulse", {31'd0, pf_flush}, 32'h1);
    @(negedge clk);
    check("R7 pf single", {31'd0, pf_flush}, 32'h0);
    txn(2, 1'b1, 3'd5, 32'h8, rv, wt);
    @(negedge clk);
    check("R7 sync no pulse", {31'd0, pf_flush}, 32'h0);

    // R2 same-cycle claims: port 1 beats port 2
    @(negedge clk);
    req = 3'b110; we = 3'b110;
    addr = {3'd0, 3'd0, 3'd0};
    wdata = {32'h0002_8002, 32'h0002_8001, 32'h0};
    @(posedge clk); #1;
    req = '0; we = '0;
    txn(2, 1'b0, 3'd3, 32'h0, rv, wt); check("R2 loser refused", rv, 32'h1);
    txn(1, 1'b0, 3'd3, 32'h0, rv, wt); check("R2 winner commits", rv, 32'h0);
    txn(2, 1'b0, 3'd3, 32'h0, rv, wt); check("R3 flag cleared", rv, 32'h0);
    txn(0, 1'b0, 3'd5, 32'h0, rv, wt);
    check("R2 rec count", nrec, 32'd5);
    check("R2 winner ran", {28'd0, r_cpu[4]}, 32'd1);
    check("R2 winner cmd", {28'd0, r_cmd[4]}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule